// File: doc/BRIEF.md
# Horizontal Blanking Generator with Clock-Phase Masking

This block runs a pixel counter that restarts at every horizontal sync. From that counter it builds a horizontal blanking window. The window opens and closes at up to six programmed pixel positions in each line. There is no start-level setting: the window is always inactive when a line begins. Each match inverts it.

A two-bit alternation setting splits the six positions into a pair (the first two) and a group of four (the other four). The pair then serves lines of one parity and the group serves lines of the other. The line parity flips on every sync, and a field-start flag given with a sync forces the new line to odd.

The four horizontal clock phases enter from outside, and the block passes them through one register. While blanking is active, that register loads a fixed mask pattern instead. The pattern is chosen by a mask-polarity bit. Ten complete register sets sit on a flat configuration bus. The set number presented at each sync picks the set used for the whole line.

Top module: `hblk_gen`

## Requirements
- R1: A clock with `hsync` high sets the pixel index to 0. Every other clock adds one to it, and it stays at 4095 once there.
- R2: `blank` is 0 from the clock that takes `hsync`. After that it changes only on the clock edge that ends a cycle in which the pixel index equals an active toggle position. An inversion at position T first shows while the index is T+1.
- R3: A toggle value of 4095 never inverts `blank`, including while the index is held at 4095.
- R4: Each active toggle that matches inverts `blank` once. Two active toggles at the same position therefore leave it unchanged.
- R5: Alternation mode per set, where the pair is toggles 0–1 and the group is toggles 2–5. Mode 0 uses all six on every line. Mode 1 uses the pair on odd lines and the group on even lines. Modes 2 and 3 use the pair on even lines and the group on odd lines.
- R6: Line parity is even after reset. It flips at each `hsync`, except that `hsync` together with `field_start` makes the new line odd. `field_start` without `hsync` has no effect.
- R7: `seq_sel` is taken at `hsync` and holds for the line. A value of 10 or more is ignored, and the previous set stays in use.
- R8: While `blank` is 1, `h_out` (bit 0 = H1 … bit 3 = H4) is 4'b1010 when the line's mask bit is 1 and 4'b0101 when it is 0.
- R9: While `blank` is 0, `h_out` equals `h_in` as sampled on the same clock edge. `h_out` and `blank` update on the same edge.
- R10: Reset (`rst_n` low, asynchronous) gives `blank`=0, `h_out`=0, set 0, pixel index 0 and even parity.
- R11: Configuration packing: set s toggle i is `cfg_tog[(s*6+i)*12 +: 12]`, the mode of set s is `cfg_alt[s*2 +: 2]`, and its mask bit is `cfg_mask[s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Line start, one clock wide |
| field_start | input | 1 | With `hsync`: the new line is odd |
| seq_sel | input | 4 | Register set number for the next line |
| cfg_tog | input | 720 | Toggle positions, 10 sets × 6 × 12 bits |
| cfg_alt | input | 20 | Alternation mode, 2 bits per set |
| cfg_mask | input | 10 | Mask polarity, 1 bit per set |
| h_in | input | 4 | Free-running horizontal clock phases H1..H4 |
| blank | output | 1 | Blanking window, active high |
| h_out | output | 4 | Masked, registered clock phases |

## Verification
A toggle at position T inverts `blank` on the edge where the index equals T. After a sync edge, the index first reads 0, so the change shows one clock after the index reads T. `h_out` shows `h_in` one edge after it is driven. Parity and set choice apply from the sync edge onward. The reference model advances on every rising edge from the inputs the bench drove at the preceding falling edge. Outputs are compared with the model at the next falling edge, so each result is sampled exactly one edge after its cause. Per-line counts of blanking cycles, worked out by hand from the toggle spacing, cross-check the model for each alternation mode and corner case.

// File: rtl/hblk_pkg.sv
package hblk_pkg;
  localparam int unsigned NUM_PH = 4;

  // Whether one toggle takes part on this line, given the mode and parity.
  function automatic logic tog_active(input logic [1:0] alt, input logic odd,
                                      input logic in_pair);
    logic pair_line;
    case (alt)
      2'd0:    return 1'b1;
      2'd1:    pair_line = odd;
      default: pair_line = ~odd;
    endcase
    return in_pair ? pair_line : ~pair_line;
  endfunction

  // Static level pattern: H1/H3 (even index) get ~pol, H2/H4 get pol.
  function automatic logic [NUM_PH-1:0] mask_pattern(input logic pol);
    logic [NUM_PH-1:0] pat;
    for (int p = 0; p < NUM_PH; p++) pat[p] = (p % 2 == 0) ? ~pol : pol;
    return pat;
  endfunction
endpackage

// File: rtl/hblk_line_ctrl.sv
module hblk_line_ctrl #(
  parameter int unsigned PIX_W   = 12,
  parameter int unsigned NUM_SEQ = 10,
  parameter int unsigned SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             field_start,
  input  logic [SEL_W-1:0] seq_sel,
  output logic [PIX_W-1:0] pix,
  output logic [SEL_W-1:0] seq_q,
  output logic             line_odd
);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic sel_ok;
  assign sel_ok = (seq_sel < SEL_W'(NUM_SEQ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix      <= '0;
      seq_q    <= '0;
      line_odd <= 1'b0;
    end else if (hsync) begin
      pix      <= '0;
      line_odd <= field_start | ~line_odd;
      if (sel_ok) seq_q <= seq_sel;
    end else if (pix != PIX_MAX) begin
      pix <= pix + 1'b1;
    end
  end

  a_r1_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (pix == '0));
  a_r1_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && pix != PIX_MAX) |=> (pix == $past(pix) + 1'b1));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && pix == PIX_MAX) |=> (pix == PIX_MAX));
  a_r6_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !field_start) |=> (line_odd != $past(line_odd)));
  a_r6_field_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && field_start) |=> line_odd);
  a_r6_no_midline: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync |=> $stable(line_odd));
  a_r7_ignore_high: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && seq_sel >= SEL_W'(NUM_SEQ)) |=> $stable(seq_q));
  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    seq_q < SEL_W'(NUM_SEQ));
endmodule

// File: rtl/hblk_toggle_match.sv
module hblk_toggle_match
  import hblk_pkg::*;
#(
  parameter int unsigned PIX_W   = 12,
  parameter int unsigned NUM_TOG = 6,
  parameter int unsigned PAIR_N  = 2
) (
  input  logic [PIX_W-1:0]         pix,
  input  logic [NUM_TOG*PIX_W-1:0] tog,
  input  logic [1:0]               alt,
  input  logic                     line_odd,
  output logic [NUM_TOG-1:0]       hit,
  output logic                     flip
);
  localparam logic [PIX_W-1:0] UNUSED = '1;

  for (genvar i = 0; i < NUM_TOG; i++) begin : g_tog
    logic [PIX_W-1:0] pos;
    assign pos    = tog[i*PIX_W +: PIX_W];
    assign hit[i] = tog_active(alt, line_odd, (i < PAIR_N)) &&
                    (pos == pix) && (pos != UNUSED);
  end

  // Each hit inverts once, so coincident hits cancel in pairs.
  assign flip = ^hit;

  always_comb begin
    if (pix == UNUSED) a_r3_unused_quiet: assert (hit == '0);
  end
endmodule

// File: rtl/hblk_clk_mask.sv
module hblk_clk_mask
  import hblk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              flip,
  input  logic              mask_pol,
  input  logic [NUM_PH-1:0] h_in,
  output logic              blank,
  output logic [NUM_PH-1:0] h_out
);
  logic blank_nx;
  logic primed;

  assign blank_nx = hsync ? 1'b0 : (blank ^ flip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank  <= 1'b0;
      h_out  <= '0;
      primed <= 1'b0;
    end else begin
      blank  <= blank_nx;
      h_out  <= blank_nx ? mask_pattern(mask_pol) : h_in;
      primed <= 1'b1;
    end
  end

  a_r2_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> !blank);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && !flip) |=> $stable(blank));
  a_r8_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (h_out[0] == h_out[2] && h_out[1] == h_out[3] && h_out[0] != h_out[1]));
  a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !blank) |-> (h_out == $past(h_in)));
endmodule

// File: rtl/hblk_gen.sv
module hblk_gen
  import hblk_pkg::*;
#(
  parameter int unsigned PIX_W   = 12,
  parameter int unsigned NUM_TOG = 6,
  parameter int unsigned NUM_SEQ = 10,
  parameter int unsigned PAIR_N  = 2,
  localparam int unsigned SEL_W  = $clog2(NUM_SEQ),
  localparam int unsigned SET_W  = NUM_TOG * PIX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hsync,
  input  logic                       field_start,
  input  logic [SEL_W-1:0]           seq_sel,
  input  logic [NUM_SEQ*SET_W-1:0]   cfg_tog,
  input  logic [NUM_SEQ*2-1:0]       cfg_alt,
  input  logic [NUM_SEQ-1:0]         cfg_mask,
  input  logic [NUM_PH-1:0]          h_in,
  output logic                       blank,
  output logic [NUM_PH-1:0]          h_out
);
  logic [PIX_W-1:0]   pix;
  logic [SEL_W-1:0]   seq_q;
  logic               line_odd;
  logic [SET_W-1:0]   cur_tog;
  logic [1:0]         cur_alt;
  logic               cur_mask;
  logic [NUM_TOG-1:0] hit;
  logic               flip;

  hblk_line_ctrl #(.PIX_W(PIX_W), .NUM_SEQ(NUM_SEQ), .SEL_W(SEL_W)) u_line (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .field_start(field_start),
    .seq_sel(seq_sel), .pix(pix), .seq_q(seq_q), .line_odd(line_odd));

  assign cur_tog  = cfg_tog[seq_q*SET_W +: SET_W];
  assign cur_alt  = cfg_alt[seq_q*2 +: 2];
  assign cur_mask = cfg_mask[seq_q];

  hblk_toggle_match #(.PIX_W(PIX_W), .NUM_TOG(NUM_TOG), .PAIR_N(PAIR_N)) u_match (
    .pix(pix), .tog(cur_tog), .alt(cur_alt), .line_odd(line_odd),
    .hit(hit), .flip(flip));

  hblk_clk_mask u_mask (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .flip(flip), .mask_pol(cur_mask),
    .h_in(h_in), .blank(blank), .h_out(h_out));

  // R4: an odd number of hits is the only way blank can change mid-line.
  a_r4_flip_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && ($countones(hit) % 2 == 0)) |=> $stable(blank));
endmodule

// File: tb/test_hblk_gen.sv
module test_hblk_gen;
  localparam int NS = 10, NT = 6, PW = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, hsync = 1'b0, field_start = 1'b0;
  logic [3:0] seq_sel = '0, h_in = '0;
  logic [NS*NT*PW-1:0] cfg_tog;
  logic [2*NS-1:0] cfg_alt;
  logic [NS-1:0] cfg_mask;
  wire blank;
  wire [3:0] h_out;

  int tog[NS][NT];
  int alt_m[NS];
  bit msk[NS];

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < NT; i++) cfg_tog[(s*NT+i)*PW +: PW] = tog[s][i][PW-1:0];
      cfg_alt[s*2 +: 2] = alt_m[s][1:0];
      cfg_mask[s] = msk[s];
    end
  end

  hblk_gen i_hblk_gen (.clk(clk), .rst_n(rst_n), .hsync(hsync), .field_start(field_start),
    .seq_sel(seq_sel), .cfg_tog(cfg_tog), .cfg_alt(cfg_alt), .cfg_mask(cfg_mask),
    .h_in(h_in), .blank(blank), .h_out(h_out));

  // Behavioural reference
  int m_pix, m_seq;
  bit m_odd, m_blank;
  logic [3:0] m_hout;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pix = 0; m_seq = 0; m_odd = 0; m_blank = 0; m_hout = 4'b0000;
    end else begin
      automatic int hits = 0;
      automatic bit nb;
      for (int i = 0; i < NT; i++) begin
        automatic bit use_it;
        if (alt_m[m_seq] == 0) use_it = 1;
        else use_it = ((i < 2) == (m_odd == (alt_m[m_seq] == 1)));
        if (use_it && tog[m_seq][i] == m_pix && tog[m_seq][i] != 4095) hits++;
      end
      nb = hsync ? 0 : (m_blank ^ (hits % 2 == 1));
      m_hout = nb ? (msk[m_seq] ? 4'b1010 : 4'b0101) : h_in;
      m_blank = nb;
      if (hsync) begin
        m_pix = 0;
        m_odd = field_start ? 1 : !m_odd;
        if (seq_sel < NS) m_seq = int'(seq_sel);
      end else if (m_pix < 4095) m_pix++;
    end
  end

  int n_chk = 0, n_fail = 0;
  string tag = "R10";

  task automatic check(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(bit hs, bit fs, int sel, output bit b);
    @(negedge clk);
    b = blank;
    check(blank == m_blank, "blank vs model (R2)", blank, m_blank);
    check(h_out == m_hout, "h_out vs model (R8/R9)", h_out, m_hout);
    hsync = hs; field_start = fs; seq_sel = sel[3:0]; h_in = 4'($urandom);
  endtask

  task automatic run_line(int len, int sel, bit fs, int fs_mid, output int hi);
    bit b;
    hi = 0;
    cycle(1, fs, sel, b);
    for (int j = 1; j < len; j++) begin
      cycle(0, j == fs_mid, sel, b);
      if (b) hi++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int hi;
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < NT; i++) tog[s][i] = 4095;
      alt_m[s] = 0; msk[s] = 0;
    end
    // R11 packing used by all sets below
    tog[0] = '{10, 20, 30, 40, 4095, 4095}; msk[0] = 1;
    tog[1] = '{5, 15, 25, 35, 45, 50}; alt_m[1] = 1;
    tog[2] = '{5, 15, 25, 35, 45, 50}; alt_m[2] = 2; msk[2] = 1;
    tog[5] = '{5, 15, 25, 35, 45, 50}; alt_m[5] = 3;
    tog[3] = '{8, 8, 12, 20, 4095, 4095};
    tog[9] = '{0, 3, 4095, 4095, 4095, 4095}; msk[9] = 1;
    tog[4] = '{4094, 4095, 4095, 4095, 4095, 4095}; msk[4] = 1;
    alt_m[6] = 1;
    tog[7] = '{4095, 4095, 40, 4095, 4095, 4095};

    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R10";
    check(blank == 1'b0, "reset blank R10", blank, 0);
    check(h_out == 4'b0000, "reset h_out R10", h_out, 0);
    rst_n = 1'b1;

    tag = "R5"; run_line(64, 0, 1, -1, hi);
    check(hi == 20, "R5 mode 0 all six", hi, 20);
    tag = "R6"; run_line(64, 1, 1, -1, hi);
    check(hi == 10, "R6 field start odd, R5 mode 1 pair", hi, 10);
    run_line(64, 1, 0, 30, hi);
    check(hi == 15, "R6 even line, R5 mode 1 group", hi, 15);
    run_line(64, 1, 0, -1, hi);
    check(hi == 10, "R6 midline field start ignored", hi, 10);
    tag = "R5"; run_line(64, 2, 0, -1, hi);
    check(hi == 10, "R5 mode 2 even pair", hi, 10);
    run_line(64, 2, 0, -1, hi);
    check(hi == 15, "R5 mode 2 odd group", hi, 15);
    run_line(64, 5, 0, -1, hi);
    check(hi == 10, "R5 mode 3 even pair", hi, 10);
    tag = "R4"; run_line(64, 3, 0, -1, hi);
    check(hi == 8, "R4 coincident toggles cancel", hi, 8);
    tag = "R7"; run_line(64, 12, 0, -1, hi);
    check(hi == 8, "R7 select 12 ignored", hi, 8);
    run_line(64, 9, 0, -1, hi);
    check(hi == 3, "R7 set 9, toggle at 0", hi, 3);
    tag = "R2"; run_line(64, 7, 0, -1, hi);
    check(hi == 22, "R2 blank from 40 to line end", hi, 22);
    run_line(64, 7, 0, -1, hi);
    check(hi == 22, "R2 cleared at line start", hi, 22);
    tag = "R1"; run_line(4200, 4, 0, -1, hi);
    check(hi == 104, "R1 saturate, R3 4095 unused", hi, 104);
    tag = "R3"; run_line(4200, 6, 0, -1, hi);
    check(hi == 0, "R3 all toggles unused", hi, 0);
    tag = "R9"; run_line(16, 0, 0, -1, hi);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule